// File: doc/BRIEF.md
# ADC Power-Mode Conversion Sequencer

This block sits on the host side of a successive-approximation converter that has two power-down pins, a light sleep (nap) and a deep sleep (standby). It issues conversions on a fixed slot grid set by a programmed period. For each slot it pulses convert-start, waits for the converter's busy line to fall and rise again, and then runs a chip-select/read cycle that captures a 13-bit result word. Each captured word leaves the block as a one-cycle sample strobe.

The sequencer enforces every settling rule the converter needs, with all delays counted in clock cycles and set by parameters:

- **Wake-up after nap.** A fixed delay follows the release of nap.
- **Wake-up after standby.** The delay depends on whether the internal or an external reference is selected.
- **Quiet time.** A minimum gap separates the end of a read from the next convert-start edge.

When nap-per-sample is enabled, the converter sleeps between slots. The sequence for each slot is:

1. Release nap.
2. Wait the nap wake-up time.
3. Convert.
4. Read.
5. Re-assert nap.

Nap cannot be used with the internal reference. If that combination is requested, the block flags a configuration error and never asserts nap.

Top module: `adc_pwr_sequencer`

## Requirements
- R1: `adc_nap` and `adc_stby` are never high together. `adc_stby` is high for as long as a standby request is honoured. No convert-start edge occurs while the converter is in standby.
- R2: After `adc_nap` falls, at least `WAKE_NAP_CYC` cycles pass before the next falling edge of `adc_convst_n`.
- R3: When nap-per-sample is requested with the internal reference selected (`cfg_ext_ref`=0), `cfg_err` is 1 and `adc_nap` never rises. With the external reference, `cfg_err` is 0.
- R4: After `adc_stby` falls, the next convert-start edge comes at least `STBY_INT_CYC` cycles later with the internal reference, or at least `STBY_EXT_CYC` cycles later with the external reference. With the external reference it comes no later than `STBY_EXT_CYC` plus one sample period plus two cycles.
- R5: At least `QUIET_CYC` cycles pass between the read strobe going high and the next falling edge of `adc_convst_n`.
- R6: `adc_convst_n` goes low for exactly `CONV_LOW_CYC` cycles. `adc_cs_n` and `adc_rd_n` go low together and stay low for exactly `RD_LOW_CYC` cycles.
- R7: `adc_rd_n` is never low while `adc_busy` is low. A read starts only after busy has fallen and risen again following convert-start.
- R8: `smp_valid` is a one-cycle pulse in the cycle after the read strobe ends. `smp_data` then equals the word the converter drove during that read.
- R9: With nap-per-sample enabled and the external reference selected, `adc_nap` rises right after each read and stays high until the next slot.
- R10: A slot that arrives while a previous sample is still in progress raises `overrun` for one cycle, and that slot starts no conversion. Slots that arrive during standby or the standby wake-up are dropped without `overrun`.
- R11: In reset and right after it, `adc_convst_n`, `adc_cs_n` and `adc_rd_n` are 1, and `adc_nap`, `adc_stby`, `smp_valid` and `overrun` are 0.
- R12: Convert-start edges fall only on slot boundaries, so the spacing between any two of them is a whole multiple of `cfg_period` (which must be at least 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | PER_W | Slot period in cycles (at least 1) |
| cfg_nap_each | input | 1 | Nap between samples |
| cfg_ext_ref | input | 1 | 1: external reference, 0: internal reference |
| stby_req | input | 1 | Request standby power-down |
| adc_busy | input | 1 | Converter busy (low while converting) |
| adc_data | input | DATA_W | Converter data bus |
| adc_convst_n | output | 1 | Convert-start, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_nap | output | 1 | Nap power-down pin |
| adc_stby | output | 1 | Standby power-down pin |
| smp_valid | output | 1 | Sample strobe |
| smp_data | output | DATA_W | Captured sample word |
| overrun | output | 1 | Slot skipped because a sample was still in progress |
| cfg_err | output | 1 | Nap requested with internal reference |

## Verification
The bound checker watches every cycle for the following:

- the pin exclusion rule;
- reads while busy is low;
- the exact convert and read strobe widths;
- the minimum nap, standby and quiet gaps before each convert-start edge;
- the timing of the sample strobe after a read.

Other properties need whole scenarios to show, so only the bench covers them:

- that data words arrive intact;
- that overruns occur for a short period and not for a long one;
- that convert-start spacing stays on the slot grid;
- that the standby delay switches with the reference source;
- that nap is refused with the internal reference.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STBY,
        S_WAKE_STBY,
        S_WAKE_NAP,
        S_CONV,
        S_BSY_LO,
        S_BSY_HI,
        S_READ,
        S_QUIET
    } seq_state_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_slot_timer.sv
module adc_seq_slot_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             tick
);
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == '0);
        cnt_d = tick ? (period - PER_W'(1)) : (cnt_q - PER_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_wake_sel.sv
module adc_seq_wake_sel #(
    parameter int STBY_INT_CYC = 50_000_000,
    parameter int STBY_EXT_CYC = 8_000,
    parameter int CNT_W        = 26
) (
    input  logic             ext_ref,
    input  logic             nap_each,
    output logic [CNT_W-1:0] stby_delay,
    output logic             nap_allow,
    output logic             cfg_err
);
    always_comb begin
        stby_delay = ext_ref ? CNT_W'(STBY_EXT_CYC - 1) : CNT_W'(STBY_INT_CYC - 1);
        nap_allow  = nap_each & ext_ref;
        cfg_err    = nap_each & ~ext_ref;
    end
endmodule

// File: rtl/adc_pwr_sequencer.sv
module adc_pwr_sequencer
    import adc_seq_pkg::*;
#(
    parameter int PER_W        = 16,
    parameter int DATA_W       = 13,
    parameter int WAKE_NAP_CYC = 30,
    parameter int STBY_INT_CYC = 50_000_000,
    parameter int STBY_EXT_CYC = 8_000,
    parameter int QUIET_CYC    = 10,
    parameter int CONV_LOW_CYC = 1,
    parameter int RD_LOW_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              cfg_nap_each,
    input  logic              cfg_ext_ref,
    input  logic              stby_req,
    input  logic              adc_busy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_convst_n,
    output logic              adc_cs_n,
    output logic              adc_rd_n,
    output logic              adc_nap,
    output logic              adc_stby,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data,
    output logic              overrun,
    output logic              cfg_err
);
    localparam int unsigned MAX_DLY = max2(max2(STBY_INT_CYC, STBY_EXT_CYC),
                                           max2(max2(WAKE_NAP_CYC, QUIET_CYC),
                                                max2(CONV_LOW_CYC, RD_LOW_CYC)));
    localparam int CNT_W = $clog2(MAX_DLY + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              nap;
        logic              stby;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              ovr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic             slot_tick;
    logic [CNT_W-1:0] stby_delay;
    logic             nap_allow;

    adc_seq_slot_timer #(.PER_W(PER_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_period),
        .tick   (slot_tick)
    );

    adc_seq_wake_sel #(
        .STBY_INT_CYC (STBY_INT_CYC),
        .STBY_EXT_CYC (STBY_EXT_CYC),
        .CNT_W        (CNT_W)
    ) u_wake (
        .ext_ref    (cfg_ext_ref),
        .nap_each   (cfg_nap_each),
        .stby_delay (stby_delay),
        .nap_allow  (nap_allow),
        .cfg_err    (cfg_err)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.ovr   = 1'b0;
        case (r_q.state)
            S_IDLE: begin
                if (stby_req) begin
                    r_d.state = S_STBY;
                    r_d.stby  = 1'b1;
                    r_d.nap   = 1'b0;
                end else if (slot_tick) begin
                    if (r_q.nap) begin
                        r_d.state = S_WAKE_NAP;
                        r_d.nap   = 1'b0;
                        r_d.cnt   = CNT_W'(WAKE_NAP_CYC - 1);
                    end else begin
                        r_d.state = S_CONV;
                        r_d.cnt   = CNT_W'(CONV_LOW_CYC - 1);
                    end
                end
            end
            S_STBY: begin
                if (!stby_req) begin
                    r_d.state = S_WAKE_STBY;
                    r_d.stby  = 1'b0;
                    r_d.cnt   = stby_delay;
                end
            end
            S_WAKE_STBY: begin
                if (r_q.cnt == '0) r_d.state = S_IDLE;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            S_WAKE_NAP: begin
                if (r_q.cnt == '0) begin
                    r_d.state = S_CONV;
                    r_d.cnt   = CNT_W'(CONV_LOW_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_CONV: begin
                if (r_q.cnt == '0) r_d.state = S_BSY_LO;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            S_BSY_LO: begin
                if (!adc_busy) r_d.state = S_BSY_HI;
            end
            S_BSY_HI: begin
                if (adc_busy) begin
                    r_d.state = S_READ;
                    r_d.cnt   = CNT_W'(RD_LOW_CYC - 1);
                end
            end
            S_READ: begin
                if (r_q.cnt == '0) begin
                    r_d.state = S_QUIET;
                    r_d.data  = adc_data;
                    r_d.valid = 1'b1;
                    r_d.nap   = nap_allow;
                    r_d.cnt   = CNT_W'(QUIET_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_QUIET: begin
                if (r_q.cnt == '0) r_d.state = S_IDLE;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            default: r_d.state = S_IDLE;
        endcase
        if (slot_tick && !(r_q.state inside {S_IDLE, S_STBY, S_WAKE_STBY}))
            r_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_convst_n = (r_q.state != S_CONV);
    assign adc_cs_n     = (r_q.state != S_READ);
    assign adc_rd_n     = (r_q.state != S_READ);
    assign adc_nap      = r_q.nap;
    assign adc_stby     = r_q.stby;
    assign smp_valid    = r_q.valid;
    assign smp_data     = r_q.data;
    assign overrun      = r_q.ovr;
endmodule

// File: rtl/adc_pwr_sequencer_chk.sv
module adc_pwr_sequencer_chk #(
    parameter int WAKE_NAP_CYC = 30,
    parameter int STBY_INT_CYC = 50_000_000,
    parameter int STBY_EXT_CYC = 8_000,
    parameter int QUIET_CYC    = 10,
    parameter int CONV_LOW_CYC = 1,
    parameter int RD_LOW_CYC   = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_ext_ref,
    input logic adc_busy,
    input logic adc_convst_n,
    input logic adc_cs_n,
    input logic adc_rd_n,
    input logic adc_nap,
    input logic adc_stby,
    input logic smp_valid
);
    localparam int unsigned BIG = adc_seq_pkg::max2(adc_seq_pkg::max2(STBY_INT_CYC, STBY_EXT_CYC),
                                                    adc_seq_pkg::max2(WAKE_NAP_CYC, QUIET_CYC));
    localparam int GAP_W = $clog2(BIG + 2) + 1;
    localparam logic [GAP_W-1:0] SAT = '1;

    logic [GAP_W-1:0] nap_gap, stby_gap, quiet_gap, conv_len, rd_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nap_gap   <= SAT;
            stby_gap  <= SAT;
            quiet_gap <= SAT;
            conv_len  <= '0;
            rd_len    <= '0;
        end else begin
            nap_gap   <= adc_nap  ? '0 : ((nap_gap   == SAT) ? SAT : nap_gap   + 1'b1);
            stby_gap  <= adc_stby ? '0 : ((stby_gap  == SAT) ? SAT : stby_gap  + 1'b1);
            quiet_gap <= !adc_rd_n ? '0 : ((quiet_gap == SAT) ? SAT : quiet_gap + 1'b1);
            conv_len  <= adc_convst_n ? '0 : conv_len + 1'b1;
            rd_len    <= adc_rd_n ? '0 : rd_len + 1'b1;
        end
    end

    AST_PINS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_nap && adc_stby)); // R1

    AST_NO_CONV_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        adc_stby |-> adc_convst_n); // R1

    AST_NAP_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> (nap_gap >= GAP_W'(WAKE_NAP_CYC))); // R2

    AST_NAP_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_nap) |-> $past(cfg_ext_ref)); // R3

    AST_STBY_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |->
            (stby_gap >= (cfg_ext_ref ? GAP_W'(STBY_EXT_CYC) : GAP_W'(STBY_INT_CYC)))); // R4

    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_convst_n) |-> (quiet_gap >= GAP_W'(QUIET_CYC))); // R5

    AST_CONV_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_convst_n) |-> (conv_len == GAP_W'(CONV_LOW_CYC))); // R6

    AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> (rd_len == GAP_W'(RD_LOW_CYC))); // R6

    AST_CS_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n == adc_rd_n); // R6

    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> adc_busy); // R7

    AST_VALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ($past(!adc_rd_n) && adc_rd_n)); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R8
endmodule

bind adc_pwr_sequencer adc_pwr_sequencer_chk #(
    .WAKE_NAP_CYC (WAKE_NAP_CYC),
    .STBY_INT_CYC (STBY_INT_CYC),
    .STBY_EXT_CYC (STBY_EXT_CYC),
    .QUIET_CYC    (QUIET_CYC),
    .CONV_LOW_CYC (CONV_LOW_CYC),
    .RD_LOW_CYC   (RD_LOW_CYC)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ext_ref  (cfg_ext_ref),
    .adc_busy     (adc_busy),
    .adc_convst_n (adc_convst_n),
    .adc_cs_n     (adc_cs_n),
    .adc_rd_n     (adc_rd_n),
    .adc_nap      (adc_nap),
    .adc_stby     (adc_stby),
    .smp_valid    (smp_valid)
);

// File: tb/test_adc_pwr_sequencer.sv
module test_adc_pwr_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int PER_W  = 16;
    localparam int DATA_W = 13;
    localparam int WAKE_N = 30;
    localparam int S_INT  = 2000;
    localparam int S_EXT  = 400;
    localparam int QUIET  = 10;
    localparam int CLOW   = 2;
    localparam int RLOW   = 3;
    localparam int BUSY_T = 30;

    typedef struct packed {
        logic [15:0] period;
        logic        nap;
        logic        ext;
        logic        exp_ovr;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{16'd100, 1'b0, 1'b0, 1'b0, 1'b0},
        '{16'd120, 1'b1, 1'b1, 1'b0, 1'b0},
        '{16'd120, 1'b1, 1'b0, 1'b0, 1'b1},
        '{16'd40,  1'b0, 1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PER_W-1:0] cfg_period = 16'd100;
    logic cfg_nap_each = 1'b0;
    logic cfg_ext_ref = 1'b0;
    logic stby_req = 1'b0;
    logic adc_busy;
    logic [DATA_W-1:0] adc_data;
    logic adc_convst_n, adc_cs_n, adc_rd_n, adc_nap, adc_stby;
    logic smp_valid, overrun, cfg_err;
    logic [DATA_W-1:0] smp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pwr_sequencer #(
        .PER_W(PER_W), .DATA_W(DATA_W), .WAKE_NAP_CYC(WAKE_N),
        .STBY_INT_CYC(S_INT), .STBY_EXT_CYC(S_EXT), .QUIET_CYC(QUIET),
        .CONV_LOW_CYC(CLOW), .RD_LOW_CYC(RLOW)
    ) i_adc_pwr_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
        .cfg_nap_each(cfg_nap_each), .cfg_ext_ref(cfg_ext_ref),
        .stby_req(stby_req), .adc_busy(adc_busy), .adc_data(adc_data),
        .adc_convst_n(adc_convst_n), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_nap(adc_nap), .adc_stby(adc_stby), .smp_valid(smp_valid),
        .smp_data(smp_data), .overrun(overrun), .cfg_err(cfg_err)
    );

    // converter model
    logic prev_cv = 1'b1;
    int   bcnt = 0;
    logic [DATA_W-1:0] conv_val = 13'h1A5;
    always @(posedge clk) begin
        prev_cv <= adc_convst_n;
        if (prev_cv && !adc_convst_n) begin
            bcnt     <= BUSY_T + 2;
            conv_val <= conv_val + 13'h3B7;
        end else if (bcnt > 0) begin
            bcnt <= bcnt - 1;
        end
    end
    assign adc_busy = !(bcnt > 0 && bcnt <= BUSY_T);
    assign adc_data = (!adc_cs_n && !adc_rd_n) ? conv_val : 13'h0000;

    // monitor
    int checks = 0, failures = 0;
    logic clr_req = 1'b0;
    int cyc = 0, last_cv = -1;
    int n_smp, n_ovr, n_nap_rise, n_data_bad, n_rd_busy, n_conv, n_grid_bad;
    int n_clen_bad, n_rlen_bad, min_nap, min_quiet, last_stby;
    int nap_gap = 1000000, stby_gap = 1000000, q_gap = 1000000, clen = 0, rlen = 0;
    logic m_cv = 1'b1, m_rd = 1'b1, m_nap = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (clr_req) begin
            n_smp = 0; n_ovr = 0; n_nap_rise = 0; n_data_bad = 0; n_rd_busy = 0;
            n_conv = 0; n_grid_bad = 0; n_clen_bad = 0; n_rlen_bad = 0;
            min_nap = 1000000; min_quiet = 1000000; last_stby = -1; last_cv = -1;
        end
        if (rst_n) begin
            if (smp_valid) begin
                n_smp++;
                if (smp_data != conv_val) n_data_bad++;
            end
            if (overrun) n_ovr++;
            if (adc_nap && !m_nap) n_nap_rise++;
            if (!adc_rd_n && !adc_busy) n_rd_busy++;
            nap_gap  = adc_nap  ? 0 : nap_gap + 1;
            stby_gap = adc_stby ? 0 : stby_gap + 1;
            q_gap    = !adc_rd_n ? 0 : q_gap + 1;
            if (m_cv && !adc_convst_n) begin
                n_conv++;
                if (nap_gap < min_nap) min_nap = nap_gap;
                if (q_gap < min_quiet) min_quiet = q_gap;
                last_stby = stby_gap;
                if (last_cv >= 0 && ((cyc - last_cv) % int'(cfg_period)) != 0) n_grid_bad++;
                last_cv = cyc;
            end
            if (!adc_convst_n) clen++;
            else begin
                if (!m_cv && clen != CLOW) n_clen_bad++;
                clen = 0;
            end
            if (!adc_rd_n) rlen++;
            else begin
                if (!m_rd && rlen != RLOW) n_rlen_bad++;
                rlen = 0;
            end
        end
        m_cv = adc_convst_n; m_rd = adc_rd_n; m_nap = adc_nap;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        @(posedge clk); clr_req = 1'b1;
        @(posedge clk); clr_req = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clear_stats();
        repeat (3) @(negedge clk);
        // R11 during reset
        chk(adc_convst_n && adc_cs_n && adc_rd_n, "R11 strobes in reset",
            {adc_convst_n, adc_cs_n, adc_rd_n}, 7);
        chk(!adc_nap && !adc_stby && !smp_valid && !overrun, "R11 flags in reset",
            {adc_nap, adc_stby, smp_valid, overrun}, 0);
        @(posedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n && adc_rd_n && !adc_nap && !adc_stby && !smp_valid,
            "R11 after reset", {adc_cs_n, adc_rd_n, adc_nap, adc_stby, smp_valid}, 5'b11000);

        for (int v = 0; v < 4; v++) begin
            cfg_period   = VECS[v].period;
            cfg_nap_each = VECS[v].nap;
            cfg_ext_ref  = VECS[v].ext;
            repeat (250) @(posedge clk);
            clear_stats();
            repeat (1500) @(posedge clk);
            @(negedge clk);
            chk(n_smp > 3, $sformatf("R8 samples v%0d", v), n_smp, 4);
            chk(n_data_bad == 0, $sformatf("R8 data v%0d", v), n_data_bad, 0);
            chk((n_ovr > 0) == VECS[v].exp_ovr, $sformatf("R10 overrun v%0d", v),
                n_ovr, int'(VECS[v].exp_ovr));
            chk(cfg_err == VECS[v].exp_err, $sformatf("R3 cfg_err v%0d", v),
                int'(cfg_err), int'(VECS[v].exp_err));
            chk((n_nap_rise > 0) == (VECS[v].nap && VECS[v].ext),
                $sformatf("R9 R3 nap use v%0d", v), n_nap_rise, int'(VECS[v].nap && VECS[v].ext));
            if (VECS[v].nap && VECS[v].ext)
                chk(n_nap_rise == n_smp || n_nap_rise == n_smp + 1, $sformatf("R9 nap per sample v%0d", v),
                    n_nap_rise, n_smp);
            chk(min_nap >= WAKE_N, $sformatf("R2 nap wake v%0d", v), min_nap, WAKE_N);
            chk(min_quiet >= QUIET, $sformatf("R5 quiet v%0d", v), min_quiet, QUIET);
            chk(n_rd_busy == 0, $sformatf("R7 read vs busy v%0d", v), n_rd_busy, 0);
            chk(n_clen_bad == 0 && n_rlen_bad == 0, $sformatf("R6 widths v%0d", v),
                n_clen_bad + n_rlen_bad, 0);
            chk(n_grid_bad == 0, $sformatf("R12 slot grid v%0d", v), n_grid_bad, 0);
            if (VECS[v].exp_ovr)
                chk(n_conv < 1500 / int'(VECS[v].period), $sformatf("R10 skipped slots v%0d", v),
                    n_conv, 1500 / int'(VECS[v].period));
        end

        // standby with internal then external reference
        for (int e = 0; e < 2; e++) begin
            cfg_period = 16'd100; cfg_nap_each = 1'b0; cfg_ext_ref = logic'(e);
            repeat (200) @(posedge clk);
            stby_req = 1'b1;
            repeat (200) @(posedge clk);
            @(negedge clk);
            chk(adc_stby && !adc_nap, $sformatf("R1 standby pins e%0d", e),
                {adc_stby, adc_nap}, 2);
            clear_stats();
            repeat (600) @(posedge clk);
            @(negedge clk);
            chk(n_conv == 0 && n_ovr == 0, $sformatf("R1 R10 idle in standby e%0d", e),
                n_conv + n_ovr, 0);
            stby_req = 1'b0;
            for (int w = 0; w < 5000 && n_smp == 0; w++) @(negedge clk);
            if (e == 0)
                chk(last_stby >= S_INT, "R4 internal ref wake", last_stby, S_INT);
            else
                chk(last_stby >= S_EXT && last_stby <= S_EXT + 100 + 2, "R4 external ref wake",
                    last_stby, S_EXT);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule